// File: doc/BRIEF.md
# Bad-Block Marker Bit Swapper

This block exchanges the bad-block marker byte between a page data buffer and byte 0 of the spare (auxiliary) buffer. An ECC engine inserts parity bits between data chunks, so the byte that sits at the marker's physical location can land at any bit position in the ECC view of the page. That byte can therefore straddle two adjacent data bytes. On each start pulse the block reads the two data bytes at a configured byte offset and also reads spare byte 0. It extracts the unaligned byte, puts the old spare byte in its place, and writes spare byte 0 and both data bytes back.

The swap is its own inverse. The same request prepares a page before programming and restores it after a read. The data buffer is reached through a byte-wide memory port with one cycle of read latency. The spare byte is reached through a separate read/write strobe pair with the same latency. The byte offset and bit offset are sampled on the accepted start pulse.

Top module: `mark_swap_top`

## Requirements
- R1: After reset, busy and done are low and no read or write strobe is active on either port.
- R2: The byte written to spare byte 0 equals bits [b+7:b] of the 16-bit word {hi, lo}, where lo is the data byte at offset A, hi is the byte at A+1 and b is the bit offset (0..7).
- R3: The new byte at A keeps its bits below b, and its bits b..7 take bits 0..7-b of the old spare byte.
- R4: The new byte at A+1 keeps its bits b..7, and its bits 0..b-1 take bits 8-b..7 of the old spare byte.
- R5: With b = 0 no write goes to A+1, which keeps its value, and the operation is a plain byte exchange between A and spare byte 0.
- R6: Two swaps in a row with the same offsets restore the spare byte and all data bytes to their original values.
- R7: Every read (A, A+1, spare) is issued before the first write. The writes go in this order: spare byte, then A, then A+1 (when b is not 0). No other data address is written, and A+1 wraps modulo the buffer size.
- R8: A start pulse while busy is high is ignored: its offsets are not used and it does not cause a second operation.
- R9: Busy is high from the cycle after an accepted start until done. Done is high for exactly one cycle, the cycle after the last write strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request a swap (sampled while idle) |
| byte_ofs | input | ADDR_W | Data byte offset A of the marker's low byte |
| bit_ofs | input | $clog2(DATA_W) | Bit offset b inside byte A |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| pg_addr | output | ADDR_W | Data buffer address |
| pg_rd_en | output | 1 | Data buffer read strobe |
| pg_rdata | input | DATA_W | Data buffer read data, one cycle after the strobe |
| pg_we | output | 1 | Data buffer write strobe |
| pg_wdata | output | DATA_W | Data buffer write data |
| aux_rd_en | output | 1 | Spare byte 0 read strobe |
| aux_rdata | input | DATA_W | Spare byte 0 read data, one cycle after the strobe |
| aux_we | output | 1 | Spare byte 0 write strobe |
| aux_wdata | output | DATA_W | Spare byte 0 write data |

## Verification
A wrongly captured byte or bit offset shows up at the ports within one operation. It appears as a wrong value or a wrong address on the write strobes, which fall four to six cycles after start. A sequencer that skips or reorders states shows up as a read strobe after a write, a missing or extra write to A+1, or a done pulse that lasts two cycles or never arrives. Running the swap twice and checking that the original bytes come back exposes any asymmetry between the extract and insert paths, and it does so without an independent model.

// File: rtl/mswap_pkg.sv
package mswap_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD_HI,
    ST_CAP_LO,
    ST_CAP_HI,
    ST_PUT_AUX,
    ST_PUT_LO,
    ST_PUT_HI,
    ST_LAST
  } mswap_state_e;
endpackage

// File: rtl/mswap_merge.sv
module mswap_merge #(
  parameter int DATA_W = 8
) (
  input  logic [DATA_W-1:0]         lo,
  input  logic [DATA_W-1:0]         hi,
  input  logic [DATA_W-1:0]         aux,
  input  logic [$clog2(DATA_W)-1:0] sh,
  output logic [DATA_W-1:0]         marker,
  output logic [DATA_W-1:0]         new_lo,
  output logic [DATA_W-1:0]         new_hi
);
  localparam int W2 = 2 * DATA_W;

  logic [W2-1:0] pair, shifted, keep, ins, mixed;

  always_comb begin
    pair    = {hi, lo};
    shifted = pair >> sh;
    keep    = ~({{DATA_W{1'b0}}, {DATA_W{1'b1}}} << sh);
    ins     = {{DATA_W{1'b0}}, aux} << sh;
    mixed   = (pair & keep) | ins;
    marker  = shifted[DATA_W-1:0];
    new_lo  = mixed[DATA_W-1:0];
    new_hi  = mixed[W2-1:DATA_W];
  end
endmodule

// File: rtl/mswap_seq.sv
module mswap_seq
  import mswap_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 10
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      start,
  input  logic [ADDR_W-1:0]         byte_ofs,
  input  logic [$clog2(DATA_W)-1:0] bit_ofs,
  input  logic [DATA_W-1:0]         pg_rdata,
  input  logic [DATA_W-1:0]         aux_rdata,
  input  logic [DATA_W-1:0]         marker,
  input  logic [DATA_W-1:0]         new_lo,
  input  logic [DATA_W-1:0]         new_hi,
  output logic [DATA_W-1:0]         lo_q,
  output logic [DATA_W-1:0]         hi_q,
  output logic [DATA_W-1:0]         aux_q,
  output logic [$clog2(DATA_W)-1:0] sh_q,
  output logic                      busy,
  output logic                      done,
  output logic [ADDR_W-1:0]         pg_addr,
  output logic                      pg_rd_en,
  output logic                      pg_we,
  output logic [DATA_W-1:0]         pg_wdata,
  output logic                      aux_rd_en,
  output logic                      aux_we,
  output logic [DATA_W-1:0]         aux_wdata
);
  localparam int SH_W = $clog2(DATA_W);

  mswap_state_e      st;
  logic [ADDR_W-1:0] base_q;
  logic [ADDR_W-1:0] next_addr;

  assign next_addr = base_q + ADDR_W'(1);
  assign busy      = (st != ST_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= ST_IDLE;
      base_q    <= '0;
      sh_q      <= '0;
      lo_q      <= '0;
      hi_q      <= '0;
      aux_q     <= '0;
      done      <= 1'b0;
      pg_addr   <= '0;
      pg_rd_en  <= 1'b0;
      pg_we     <= 1'b0;
      pg_wdata  <= '0;
      aux_rd_en <= 1'b0;
      aux_we    <= 1'b0;
      aux_wdata <= '0;
    end else begin
      done <= 1'b0;
      unique case (st)
        ST_IDLE: begin
          if (start) begin
            base_q    <= byte_ofs;
            sh_q      <= SH_W'(bit_ofs);
            pg_addr   <= byte_ofs;
            pg_rd_en  <= 1'b1;
            aux_rd_en <= 1'b1;
            st        <= ST_RD_HI;
          end
        end
        ST_RD_HI: begin
          pg_addr   <= next_addr;
          aux_rd_en <= 1'b0;
          st        <= ST_CAP_LO;
        end
        ST_CAP_LO: begin
          lo_q     <= pg_rdata;
          aux_q    <= aux_rdata;
          pg_rd_en <= 1'b0;
          st       <= ST_CAP_HI;
        end
        ST_CAP_HI: begin
          hi_q <= pg_rdata;
          st   <= ST_PUT_AUX;
        end
        ST_PUT_AUX: begin
          aux_we    <= 1'b1;
          aux_wdata <= marker;
          st        <= ST_PUT_LO;
        end
        ST_PUT_LO: begin
          aux_we   <= 1'b0;
          pg_we    <= 1'b1;
          pg_addr  <= base_q;
          pg_wdata <= new_lo;
          st       <= ST_PUT_HI;
        end
        ST_PUT_HI: begin
          if (sh_q != '0) begin
            pg_addr  <= next_addr;
            pg_wdata <= new_hi;
            st       <= ST_LAST;
          end else begin
            pg_we <= 1'b0;
            done  <= 1'b1;
            st    <= ST_IDLE;
          end
        end
        ST_LAST: begin
          pg_we <= 1'b0;
          done  <= 1'b1;
          st    <= ST_IDLE;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/mark_swap_top.sv
module mark_swap_top #(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 10
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      start,
  input  logic [ADDR_W-1:0]         byte_ofs,
  input  logic [$clog2(DATA_W)-1:0] bit_ofs,
  output logic                      busy,
  output logic                      done,
  output logic [ADDR_W-1:0]         pg_addr,
  output logic                      pg_rd_en,
  input  logic [DATA_W-1:0]         pg_rdata,
  output logic                      pg_we,
  output logic [DATA_W-1:0]         pg_wdata,
  output logic                      aux_rd_en,
  input  logic [DATA_W-1:0]         aux_rdata,
  output logic                      aux_we,
  output logic [DATA_W-1:0]         aux_wdata
);
  localparam int SH_W = $clog2(DATA_W);

  logic [DATA_W-1:0] lo_q, hi_q, aux_q;
  logic [SH_W-1:0]   sh_q;
  logic [DATA_W-1:0] marker, new_lo, new_hi;

  mswap_merge #(.DATA_W(DATA_W)) merge_i (
    .lo     (lo_q),
    .hi     (hi_q),
    .aux    (aux_q),
    .sh     (sh_q),
    .marker (marker),
    .new_lo (new_lo),
    .new_hi (new_hi)
  );

  mswap_seq #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) seq_i (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .byte_ofs  (byte_ofs),
    .bit_ofs   (bit_ofs),
    .pg_rdata  (pg_rdata),
    .aux_rdata (aux_rdata),
    .marker    (marker),
    .new_lo    (new_lo),
    .new_hi    (new_hi),
    .lo_q      (lo_q),
    .hi_q      (hi_q),
    .aux_q     (aux_q),
    .sh_q      (sh_q),
    .busy      (busy),
    .done      (done),
    .pg_addr   (pg_addr),
    .pg_rd_en  (pg_rd_en),
    .pg_we     (pg_we),
    .pg_wdata  (pg_wdata),
    .aux_rd_en (aux_rd_en),
    .aux_we    (aux_we),
    .aux_wdata (aux_wdata)
  );
endmodule

// File: rtl/mswap_chk.sv
module mswap_chk (
  input logic clk,
  input logic rst,
  input logic busy,
  input logic done,
  input logic pg_rd_en,
  input logic pg_we,
  input logic aux_rd_en,
  input logic aux_we
);
  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (rst)
    !busy |-> (!pg_rd_en && !pg_we && !aux_rd_en && !aux_we));

  assert_one_write_R7: assert property (@(posedge clk) disable iff (rst)
    $onehot0({pg_we, aux_we, pg_rd_en}));

  assert_lo_after_aux_R7: assert property (@(posedge clk) disable iff (rst)
    aux_we |=> pg_we);

  assert_done_single_R9: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  assert_done_after_write_R9: assert property (@(posedge clk) disable iff (rst)
    $rose(done) |-> $past(pg_we));
endmodule

bind mark_swap_top mswap_chk chk_i (
  .clk       (clk),
  .rst       (rst),
  .busy      (busy),
  .done      (done),
  .pg_rd_en  (pg_rd_en),
  .pg_we     (pg_we),
  .aux_rd_en (aux_rd_en),
  .aux_we    (aux_we)
);

// File: tb/mark_swap_top_tb_top.sv
module mark_swap_top_tb_top;
  localparam int DW = 8;
  localparam int AW = 4;
  localparam int DEPTH = 1 << AW;
  localparam int NV = 7;
  // {addr[3:0], bit[2:0], lo, hi, aux}
  localparam logic [30:0] VECS [0:NV-1] = '{
    {4'd3,  3'd3, 8'hA5, 8'h3C, 8'h00},
    {4'd0,  3'd0, 8'h12, 8'h34, 8'hFF},
    {4'd7,  3'd7, 8'h80, 8'hFF, 8'h5A},
    {4'd15, 3'd4, 8'hF0, 8'h0F, 8'hC3},
    {4'd9,  3'd1, 8'h01, 8'h80, 8'h7E},
    {4'd5,  3'd6, 8'h00, 8'h00, 8'hFF},
    {4'd11, 3'd2, 8'hFF, 8'hFF, 8'h00}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic [AW-1:0] byte_ofs = '0;
  logic [2:0] bit_ofs = '0;
  logic busy, done, pg_rd_en, pg_we, aux_rd_en, aux_we;
  logic [AW-1:0] pg_addr;
  logic [DW-1:0] pg_rdata, pg_wdata, aux_rdata, aux_wdata;

  logic [DW-1:0] mem [DEPTH];
  logic [DW-1:0] aux_byte;

  int checks = 0;
  int fails = 0;

  always #4 clk = ~clk;

  mark_swap_top #(.DATA_W(DW), .ADDR_W(AW)) dut_i (
    .clk(clk), .rst(rst), .start(start), .byte_ofs(byte_ofs), .bit_ofs(bit_ofs),
    .busy(busy), .done(done), .pg_addr(pg_addr), .pg_rd_en(pg_rd_en),
    .pg_rdata(pg_rdata), .pg_we(pg_we), .pg_wdata(pg_wdata),
    .aux_rd_en(aux_rd_en), .aux_rdata(aux_rdata), .aux_we(aux_we),
    .aux_wdata(aux_wdata)
  );

  always_ff @(posedge clk) begin
    if (pg_we) mem[pg_addr] <= pg_wdata;
    if (pg_rd_en) pg_rdata <= mem[pg_addr];
    if (aux_we) aux_byte <= aux_wdata;
    if (aux_rd_en) aux_rdata <= aux_byte;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic fill_mem(input int seed);
    for (int i = 0; i < DEPTH; i++) mem[i] = DW'(i * 29 + seed);
  endtask

  // Runs one swap; watches strobes for ordering and done timing.
  task automatic run_swap(input logic [AW-1:0] a, input logic [2:0] b, input bit inject);
    int cyc = 0;
    int nwr = 0;
    bit order_ok = 1;
    logic [AW-1:0] a1 = a + 1'b1;
    byte_ofs = a;
    bit_ofs  = b;
    start    = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(busy == 1'b1, "R9 busy after start", busy, 1);
    while (!done && cyc < 40) begin
      if ((pg_rd_en || aux_rd_en) && nwr > 0) order_ok = 0;
      if (aux_we) begin
        if (nwr != 0) order_ok = 0;
        nwr++;
      end
      if (pg_we) begin
        if (nwr == 0) order_ok = 0;
        if (nwr == 1 && pg_addr != a) order_ok = 0;
        if (nwr == 2 && pg_addr != a1) order_ok = 0;
        nwr++;
      end
      if (inject && cyc == 2) begin
        start = 1'b1;
        byte_ofs = a + 4'd3;
        bit_ofs = b + 3'd1;
      end else begin
        start = 1'b0;
      end
      @(negedge clk);
      cyc++;
    end
    start = 1'b0;
    chk(done == 1'b1, "R9 done reached", done, 1);
    chk(order_ok && nwr == ((b != 0) ? 3 : 2), "R7 read/write order", nwr, (b != 0) ? 3 : 2);
    @(negedge clk);
    chk(done == 1'b0 && busy == 1'b0, "R9 done one cycle", {done, busy}, 0);
  endtask

  function automatic logic [DW-1:0] exp_marker(input logic [DW-1:0] lo, hi, input int b);
    logic [DW-1:0] r;
    for (int i = 0; i < DW; i++) r[i] = (b + i < DW) ? lo[b + i] : hi[b + i - DW];
    return r;
  endfunction

  function automatic logic [DW-1:0] exp_lo(input logic [DW-1:0] lo, ax, input int b);
    logic [DW-1:0] r;
    for (int i = 0; i < DW; i++) r[i] = (i < b) ? lo[i] : ax[i - b];
    return r;
  endfunction

  function automatic logic [DW-1:0] exp_hi(input logic [DW-1:0] hi, ax, input int b);
    logic [DW-1:0] r;
    for (int i = 0; i < DW; i++) r[i] = (i >= b) ? hi[i] : ax[i + DW - b];
    return r;
  endfunction

  task automatic check_swap(input logic [AW-1:0] a, input int b,
                            input logic [DW-1:0] lo, hi, ax,
                            input logic [DW-1:0] snap [DEPTH]);
    logic [AW-1:0] a1 = a + 1'b1;
    bit others_ok = 1;
    chk(aux_byte == exp_marker(lo, hi, b), "R2 spare byte", aux_byte, exp_marker(lo, hi, b));
    chk(mem[a] == exp_lo(lo, ax, b), "R3 low data byte", mem[a], exp_lo(lo, ax, b));
    if (b == 0)
      chk(mem[a1] == hi && aux_byte == lo && mem[a] == ax, "R5 plain exchange", mem[a1], hi);
    else
      chk(mem[a1] == exp_hi(hi, ax, b), "R4 high data byte", mem[a1], exp_hi(hi, ax, b));
    for (int i = 0; i < DEPTH; i++)
      if (AW'(i) != a && AW'(i) != a1 && mem[i] != snap[i]) others_ok = 0;
    chk(others_ok, "R7 no stray data write", others_ok, 1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [DW-1:0] snap [DEPTH];
    fill_mem(7);
    aux_byte = 8'h00;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(!busy && !done && !pg_rd_en && !pg_we && !aux_rd_en && !aux_we,
        "R1 reset idle", {busy, done, pg_rd_en, pg_we, aux_rd_en, aux_we}, 0);

    // table walk
    for (int v = 0; v < NV; v++) begin
      logic [AW-1:0] a = VECS[v][30:27];
      logic [2:0] b = VECS[v][26:24];
      logic [DW-1:0] lo = VECS[v][23:16];
      logic [DW-1:0] hi = VECS[v][15:8];
      logic [DW-1:0] ax = VECS[v][7:0];
      fill_mem(v * 13);
      mem[a] = lo;
      mem[a + 1'b1] = hi;
      aux_byte = ax;
      for (int i = 0; i < DEPTH; i++) snap[i] = mem[i];
      run_swap(a, b, 1'b0);
      check_swap(a, int'(b), lo, hi, ax, snap);
    end

    // R6: double swap restores everything
    begin
      bit same = 1;
      logic [DW-1:0] ax0;
      fill_mem(91);
      aux_byte = 8'h6D;
      ax0 = aux_byte;
      for (int i = 0; i < DEPTH; i++) snap[i] = mem[i];
      run_swap(4'd6, 3'd5, 1'b0);
      run_swap(4'd6, 3'd5, 1'b0);
      for (int i = 0; i < DEPTH; i++) if (mem[i] != snap[i]) same = 0;
      chk(same && aux_byte == ax0, "R6 self inverse", aux_byte, ax0);
    end

    // R8: start while busy is ignored
    begin
      logic [DW-1:0] lo, hi, ax;
      fill_mem(44);
      aux_byte = 8'h99;
      lo = mem[2];
      hi = mem[3];
      ax = aux_byte;
      for (int i = 0; i < DEPTH; i++) snap[i] = mem[i];
      run_swap(4'd2, 3'd3, 1'b1);
      check_swap(4'd2, 3, lo, hi, ax, snap);
      repeat (4) @(negedge clk);
      chk(!busy && !done && !pg_we && !aux_we, "R8 no second operation",
          {busy, done, pg_we, aux_we}, 0);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule